// File: doc/BRIEF.md
# Timer Output Compare Channel

This block is the compare path of a single timer channel. Software loads a 16-bit compare value as two byte writes into a staging (preload) register. The comparator never reads the staging copy. It reads a working (shadow) copy. The shadow copy is refreshed from the staging copy in one of two ways. It can follow the staging copy on every cycle. It can also wait for the update event from the time base, when the preload-enable control is set. While a two-byte write is only half done, no refresh takes place, so the comparator never sees a half-written value.

The shadow value is compared with the running counter, which gives an equality result and a greater-than result. A mode controller turns these results into a registered reference waveform. It supports frozen, set, clear and toggle on match, forced low and high, and two PWM shapes. An external clear input can force the reference low when that clear is enabled. The pin output is the reference XORed with a polarity bit. It is held at its inactive level, which equals the polarity bit, while the channel is disabled. A registered match flag reports counter-equals-compare.

Top module: `tmr_oc_channel`

## Requirements
- R1: Byte writes load only the staging register: `wr_hi` loads bits 15:8 and `wr_lo` loads bits 7:0 from `wr_data`. The comparator uses only the shadow register, so a staged value has no effect until it is transferred.
- R2: A `wr_hi` write without `wr_lo` in the same cycle sets a write-in-progress mark. A `wr_lo` write clears it. While the mark is set, no staging-to-shadow transfer occurs, and this includes a transfer on the update event.
- R3: With `preload_en` = 0, the shadow register loads the staging value on every clock edge at which the write-in-progress mark is clear. A completed high-then-low write therefore reaches the shadow register at the edge after the low-byte write.
- R4: With `preload_en` = 1, the shadow register loads only at an edge where `upd_evt` = 1 and the write-in-progress mark is clear.
- R5: `match_flag` is 1 during the cycle after an edge at which `cnt` equalled the shadow value, and is 0 otherwise.
- R6: `oc_mode` 3'b000 holds `oc_ref`, 3'b100 drives it to 0 and 3'b101 drives it to 1, updated at each clock edge.
- R7: On an edge where `cnt` equals the shadow value, mode 3'b001 sets `oc_ref` to 1, 3'b010 clears it and 3'b011 inverts it. Without a match these modes hold it.
- R8: Mode 3'b110 drives `oc_ref` to 1 when `cnt` is below the shadow value and to 0 otherwise. Mode 3'b111 drives the inverse.
- R9: When `ref_clr_en` = 1 and `ext_clr` = 1, `oc_ref` becomes 0 at the next edge in every mode. When `ref_clr_en` = 0, `ext_clr` has no effect.
- R10: With `ch_en` = 1, `oc_pin` equals the `oc_ref` value of the previous cycle XOR `out_pol`. With `ch_en` = 0, `oc_pin` equals `out_pol`. In both cases it is registered at the edge.
- R11: Synchronous `rst` clears the staging and shadow registers, the write-in-progress mark, `oc_ref`, `oc_pin` and `match_flag`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt | input | 16 | Running counter value from the time base |
| upd_evt | input | 1 | Update event pulse from the time base |
| wr_hi | input | 1 | Write strobe for compare bits 15:8 |
| wr_lo | input | 1 | Write strobe for compare bits 7:0 |
| wr_data | input | 8 | Byte written by either strobe |
| preload_en | input | 1 | 1: transfer only on update event; 0: transfer every cycle |
| oc_mode | input | 3 | Reference waveform mode |
| ref_clr_en | input | 1 | Enables external clearing of the reference |
| ext_clr | input | 1 | External clear request |
| out_pol | input | 1 | Output polarity (1 inverts the reference) |
| ch_en | input | 1 | Channel output enable |
| oc_ref | output | 1 | Registered reference waveform |
| oc_pin | output | 1 | Registered pin-level output |
| match_flag | output | 1 | Counter equalled the shadow compare value at the last edge |

## Verification
The results arrive at different latencies. `oc_ref` and `match_flag` settle one edge after the counter and mode are applied. `oc_pin` trails `oc_ref` by one more edge. A new compare value needs one extra edge after its low byte before it can produce a match when preload is off. The bench drives inputs on the falling edge, clocks once and samples on the next falling edge, so every check sees exactly one register stage. The vector table checks `oc_pin` against the reference value expected for the previous vector. The directed write tests insert an idle cycle to absorb the shadow-register stage before they apply the counter value under test.

// File: rtl/tmr_oc_pkg.sv
package tmr_oc_pkg;
  typedef enum logic [2:0] {
    OCM_FROZEN = 3'b000,
    OCM_SET    = 3'b001,
    OCM_CLR    = 3'b010,
    OCM_TOGGLE = 3'b011,
    OCM_LOW    = 3'b100,
    OCM_HIGH   = 3'b101,
    OCM_PWM_A  = 3'b110,
    OCM_PWM_B  = 3'b111
  } oc_mode_e;
endpackage

// File: rtl/tmr_oc_ccr.sv
// Double-buffered compare register: byte-wise staging, guarded shadow.
module tmr_oc_ccr #(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_hi,
  input  logic                wr_lo,
  input  logic [BYTE_W-1:0]   wr_data,
  input  logic                preload_en,
  input  logic                upd_evt,
  output logic [2*BYTE_W-1:0] shadow_q,
  output logic                wip_q
);
  localparam int NLANES = 2;
  localparam int W      = NLANES * BYTE_W;

  logic [W-1:0]      stage_q;
  logic [NLANES-1:0] lane_we;

  assign lane_we = {wr_hi, wr_lo};

  for (genvar i = 0; i < NLANES; i++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst)
        stage_q[i*BYTE_W +: BYTE_W] <= '0;
      else if (lane_we[i])
        stage_q[i*BYTE_W +: BYTE_W] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        wip_q <= 1'b0;
    else if (wr_lo) wip_q <= 1'b0;
    else if (wr_hi) wip_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)
      shadow_q <= '0;
    else if (!wip_q && (!preload_en || upd_evt))
      shadow_q <= stage_q;
  end
endmodule

// File: rtl/tmr_oc_cmp.sv
// Counter against shadow compare value.
module tmr_oc_cmp #(
  parameter int W = 16
) (
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] cmp_val,
  output logic         eq,
  output logic         gt
);
  assign eq = (cnt == cmp_val);
  assign gt = (cnt >  cmp_val);
endmodule

// File: rtl/tmr_oc_refgen.sv
// Mode controller producing the registered reference waveform.
module tmr_oc_refgen
  import tmr_oc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] mode,
  input  logic       eq,
  input  logic       gt,
  input  logic       clr,
  output logic       ref_q
);
  oc_mode_e m;
  logic     nxt;

  assign m = oc_mode_e'(mode);

  always_comb begin
    nxt = ref_q;
    unique case (m)
      OCM_FROZEN: nxt = ref_q;
      OCM_SET:    if (eq) nxt = 1'b1;
      OCM_CLR:    if (eq) nxt = 1'b0;
      OCM_TOGGLE: if (eq) nxt = ~ref_q;
      OCM_LOW:    nxt = 1'b0;
      OCM_HIGH:   nxt = 1'b1;
      OCM_PWM_A:  nxt = ~(eq | gt);
      OCM_PWM_B:  nxt = eq | gt;
      default:    nxt = ref_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)      ref_q <= 1'b0;
    else if (clr) ref_q <= 1'b0;
    else          ref_q <= nxt;
  end
endmodule

// File: rtl/tmr_oc_channel.sv
// Output compare channel top.
module tmr_oc_channel #(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [2*BYTE_W-1:0] cnt,
  input  logic                upd_evt,
  input  logic                wr_hi,
  input  logic                wr_lo,
  input  logic [BYTE_W-1:0]   wr_data,
  input  logic                preload_en,
  input  logic [2:0]          oc_mode,
  input  logic                ref_clr_en,
  input  logic                ext_clr,
  input  logic                out_pol,
  input  logic                ch_en,
  output logic                oc_ref,
  output logic                oc_pin,
  output logic                match_flag
);
  localparam int CNT_W = 2 * BYTE_W;

  logic [CNT_W-1:0] shadow_val;
  logic             wip;
  logic             cmp_eq, cmp_gt;

  tmr_oc_ccr #(.BYTE_W(BYTE_W)) u_ccr (
    .clk(clk), .rst(rst), .wr_hi(wr_hi), .wr_lo(wr_lo), .wr_data(wr_data),
    .preload_en(preload_en), .upd_evt(upd_evt),
    .shadow_q(shadow_val), .wip_q(wip)
  );

  tmr_oc_cmp #(.W(CNT_W)) u_cmp (
    .cnt(cnt), .cmp_val(shadow_val), .eq(cmp_eq), .gt(cmp_gt)
  );

  tmr_oc_refgen u_ref (
    .clk(clk), .rst(rst), .mode(oc_mode), .eq(cmp_eq), .gt(cmp_gt),
    .clr(ref_clr_en & ext_clr), .ref_q(oc_ref)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      match_flag <= 1'b0;
      oc_pin     <= 1'b0;
    end else begin
      match_flag <= cmp_eq;
      oc_pin     <= ch_en ? (oc_ref ^ out_pol) : out_pol;
    end
  end
endmodule

// File: rtl/tmr_oc_chk.sv
module tmr_oc_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] cnt,
  input logic [W-1:0] shadow_val,
  input logic         wip,
  input logic         preload_en,
  input logic         upd_evt,
  input logic [2:0]   oc_mode,
  input logic         ref_clr_en,
  input logic         ext_clr,
  input logic         out_pol,
  input logic         ch_en,
  input logic         oc_ref,
  input logic         oc_pin,
  input logic         match_flag
);
  assert_wip_hold_R2: assert property (@(posedge clk) disable iff (rst)
    wip |=> $stable(shadow_val));

  assert_preload_wait_R4: assert property (@(posedge clk) disable iff (rst)
    (preload_en && !upd_evt) |=> $stable(shadow_val));

  assert_match_R5: assert property (@(posedge clk) disable iff (rst)
    (cnt == shadow_val) |=> match_flag);

  assert_force_low_R6: assert property (@(posedge clk) disable iff (rst)
    (oc_mode == 3'b100) |=> !oc_ref);

  assert_force_high_R6: assert property (@(posedge clk) disable iff (rst)
    (oc_mode == 3'b101 && !(ref_clr_en && ext_clr)) |=> oc_ref);

  assert_ext_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (ref_clr_en && ext_clr) |=> !oc_ref);

  assert_pin_idle_R10: assert property (@(posedge clk) disable iff (rst)
    !ch_en |=> (oc_pin == $past(out_pol)));
endmodule

bind tmr_oc_channel tmr_oc_chk #(.W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .cnt(cnt), .shadow_val(shadow_val), .wip(wip),
  .preload_en(preload_en), .upd_evt(upd_evt), .oc_mode(oc_mode),
  .ref_clr_en(ref_clr_en), .ext_clr(ext_clr), .out_pol(out_pol),
  .ch_en(ch_en), .oc_ref(oc_ref), .oc_pin(oc_pin), .match_flag(match_flag)
);

// File: tb/tb_tmr_oc_channel.sv
module tb_tmr_oc_channel;
  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] cnt;
  logic        upd_evt, wr_hi, wr_lo, preload_en, ref_clr_en, ext_clr;
  logic        out_pol, ch_en;
  logic [7:0]  wr_data;
  logic [2:0]  oc_mode;
  logic        oc_ref, oc_pin, match_flag;

  int  nvec = 0;
  int  nfail = 0;
  bit  done = 1'b0;

  always #4 clk = ~clk;

  tmr_oc_channel dut (
    .clk(clk), .rst(rst), .cnt(cnt), .upd_evt(upd_evt), .wr_hi(wr_hi),
    .wr_lo(wr_lo), .wr_data(wr_data), .preload_en(preload_en),
    .oc_mode(oc_mode), .ref_clr_en(ref_clr_en), .ext_clr(ext_clr),
    .out_pol(out_pol), .ch_en(ch_en), .oc_ref(oc_ref), .oc_pin(oc_pin),
    .match_flag(match_flag)
  );

  // {cnt, mode, expected ref, expected flag}; shadow compare value is 16'h0100
  localparam logic [20:0] VEC [15] = '{
    {16'h00FF, 3'b110, 1'b1, 1'b0},  // R8 below
    {16'h0100, 3'b110, 1'b0, 1'b1},  // R8 equal, R5
    {16'h0101, 3'b110, 1'b0, 1'b0},  // R8 above
    {16'h0101, 3'b111, 1'b1, 1'b0},  // R8 inverse
    {16'h00FF, 3'b111, 1'b0, 1'b0},
    {16'h0100, 3'b111, 1'b1, 1'b1},
    {16'h0000, 3'b101, 1'b1, 1'b0},  // R6 high
    {16'h0000, 3'b100, 1'b0, 1'b0},  // R6 low
    {16'h0100, 3'b001, 1'b1, 1'b1},  // R7 set
    {16'h0005, 3'b000, 1'b1, 1'b0},  // R6 frozen
    {16'h0100, 3'b010, 1'b0, 1'b1},  // R7 clear
    {16'h0100, 3'b011, 1'b1, 1'b1},  // R7 toggle
    {16'h0100, 3'b011, 1'b0, 1'b1},
    {16'h0050, 3'b011, 1'b0, 1'b0},  // R7 no match
    {16'h0050, 3'b001, 1'b0, 1'b0}
  };

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(string req, logic act, logic exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic wbyte(bit hi, logic [7:0] d);
    wr_hi = hi; wr_lo = !hi; wr_data = d;
    step();
    wr_hi = 1'b0; wr_lo = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    logic prev;
    rst = 1'b1; cnt = '0; upd_evt = 0; wr_hi = 0; wr_lo = 0; wr_data = '0;
    preload_en = 0; oc_mode = 3'b000; ref_clr_en = 0; ext_clr = 0;
    out_pol = 0; ch_en = 1;
    @(negedge clk);
    step(); step();
    check("R11 ref reset", oc_ref, 1'b0);
    check("R11 pin reset", oc_pin, 1'b0);
    check("R11 flag reset", match_flag, 1'b0);
    rst = 1'b0;

    wbyte(1'b1, 8'h01);
    wbyte(1'b0, 8'h00);
    cnt = 16'h7777;
    oc_mode = 3'b100;
    step(); step();
    prev = 1'b0;

    for (int i = 0; i < 15; i++) begin
      cnt = VEC[i][20:5];
      oc_mode = VEC[i][4:2];
      step();
      check("R6/R7/R8 table ref", oc_ref, VEC[i][1]);
      check("R5 table flag", match_flag, VEC[i][0]);
      check("R10 table pin", oc_pin, prev);
      prev = VEC[i][1];
    end

    // R3 immediate transfer
    oc_mode = 3'b000;
    wbyte(1'b1, 8'h02); wbyte(1'b0, 8'h00); step();
    cnt = 16'h0200; step();
    check("R3 new value matches", match_flag, 1'b1);
    cnt = 16'h0100; step();
    check("R1 old value gone", match_flag, 1'b0);

    // R2 half write blocks transfer
    wbyte(1'b1, 8'h03); step(); step();
    cnt = 16'h0300; step();
    check("R2 half write not visible", match_flag, 1'b0);
    cnt = 16'h0200; step();
    check("R2 shadow kept", match_flag, 1'b1);
    wbyte(1'b0, 8'h00); step();
    cnt = 16'h0300; step();
    check("R2 completed write visible", match_flag, 1'b1);

    // R4 preload waits for update event
    preload_en = 1'b1;
    wbyte(1'b1, 8'h04); wbyte(1'b0, 8'h00); step(); step();
    cnt = 16'h0400; step();
    check("R4 staged value not used", match_flag, 1'b0);
    cnt = 16'h0300; step();
    check("R4 shadow held", match_flag, 1'b1);
    upd_evt = 1'b1; step(); upd_evt = 1'b0;
    cnt = 16'h0400; step();
    check("R4 update transfers", match_flag, 1'b1);

    // R2 update event blocked during half write
    wbyte(1'b1, 8'h05);
    upd_evt = 1'b1; step(); upd_evt = 1'b0;
    cnt = 16'h0400; step();
    check("R2 update blocked", match_flag, 1'b1);
    wbyte(1'b0, 8'h00);
    upd_evt = 1'b1; step(); upd_evt = 1'b0;
    cnt = 16'h0500; step();
    check("R4 update after completion", match_flag, 1'b1);

    // R9 external clear
    oc_mode = 3'b101; step();
    check("R6 force high", oc_ref, 1'b1);
    ref_clr_en = 1'b1; ext_clr = 1'b1; step();
    check("R9 clear wins", oc_ref, 1'b0);
    ref_clr_en = 1'b0; step();
    check("R9 clear ignored", oc_ref, 1'b1);
    ext_clr = 1'b0;

    // R10 polarity and enable
    out_pol = 1'b1; step();
    check("R10 inverted pin", oc_pin, 1'b0);
    ch_en = 1'b0; step();
    check("R10 disabled pin pol1", oc_pin, 1'b1);
    out_pol = 1'b0; step();
    check("R10 disabled pin pol0", oc_pin, 1'b0);
    ch_en = 1'b1; step();
    check("R10 enabled pin", oc_pin, 1'b1);

    // R11 reset mid-run
    cnt = 16'h0500;
    rst = 1'b1; step();
    check("R11 ref cleared", oc_ref, 1'b0);
    check("R11 flag cleared", match_flag, 1'b0);
    check("R11 pin cleared", oc_pin, 1'b0);
    rst = 1'b0; oc_mode = 3'b000; cnt = 16'h0000; step();
    check("R11 shadow cleared", match_flag, 1'b1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule